// File: doc/BRIEF.md
# Two-Level I/O Device Select Decoder

This block sits on the peripheral side of a processor's I/O port. It lets one narrow set of I/O instruction codes serve many devices, up to 256, one device at a time. One output code is set aside as a select command that every device on the bus decodes. While that command executes, the data bus carries a device number. The device whose number matches the `DEV_ID` parameter sets its selected latch, and every other device clears its own latch. The latch is sticky: later I/O codes, in both directions, reach only the device that is currently selected.

The decoder watches three things: the 3-bit I/O code, the memory-read line that gives the transfer direction, and a timing strobe. The strobe counts only while the 2-bit state code shows an execute cycle. When the device is selected, the decoder turns each output or input code into a one-cycle, one-hot strobe for the device logic and captures the bus byte of output transfers. It also passes the device's status flags to the processor only while selected. DMA cycles produce their own strobe whether or not the device is selected.

Top module: `selio_dev_select`

## Requirements
- R1: After reset `selected` is 0 and `outStrobe`, `inStrobe`, `outData` and `dmaStrobe` are all zero.
- R2: A transfer is qualified when `tpb` is 1 on a clock edge while `stateCode` is 2'b01 (execute) and `ioCode` is nonzero. If such a transfer has `memRead`=1 (output) and `ioCode` equals `SEL_CODE` (default 1), and `dataBus` equals `DEV_ID`, then `selected` is 1 from the next cycle.
- R3: A qualified select transfer whose bus byte differs from `DEV_ID` clears `selected` from the next cycle, even if the device was selected before.
- R4: A qualified output transfer (`memRead`=1) with a code other than `SEL_CODE`, while selected, raises bit `ioCode` of `outStrobe` for exactly one cycle and loads `outData` with the bus byte, both visible the cycle after the edge.
- R5: A qualified input transfer (`memRead`=0), while selected, raises bit `ioCode` of `inStrobe` for exactly one cycle, visible the cycle after the edge.
- R6: While deselected, output and input transfers raise no strobe and leave `outData` unchanged, so the device never drives the shared bus.
- R7: `flagOut` equals `devFlags` while selected and is all zeros while deselected.
- R8: Without `tpb`, or with `stateCode` other than execute (2'b00 fetch, 2'b10 DMA, 2'b11 interrupt), I/O codes have no effect: no strobe, and `selected` and `outData` keep their values.
- R9: Code 0 is not a transfer in either direction. It raises no strobe and does not change `selected`, even when the bus carries `DEV_ID`.
- R10: `tpb` while `stateCode` is 2'b10 (DMA) raises `dmaStrobe` for one cycle on the next cycle, whether or not the device is selected.
- R11: The select code never appears on `outStrobe`. An input transfer that uses the same code number (`memRead`=0) is an ordinary input and, while selected, raises that bit of `inStrobe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ioCode | input | 3 | I/O instruction code |
| memRead | input | 1 | 1 = output transfer (memory to device), 0 = input transfer |
| stateCode | input | 2 | Processor state: 00 fetch, 01 execute, 10 DMA, 11 interrupt |
| tpb | input | 1 | Data timing strobe, sampled on the clock |
| dataBus | input | DATA_W | Processor data bus byte |
| devFlags | input | FLAG_W | Status flags from the device |
| selected | output | 1 | Select latch |
| outStrobe | output | 8 | One-hot output-code strobes, indexed by code |
| inStrobe | output | 8 | One-hot input-code strobes, indexed by code |
| outData | output | DATA_W | Byte captured from the last accepted output transfer |
| flagOut | output | FLAG_W | Flags gated by the select latch |
| dmaStrobe | output | 1 | One-cycle DMA cycle strobe |

## Verification
Every cycle, the assertions check the properties that must always hold. At most one strobe is raised, and never an output and an input strobe together. No I/O strobe fires unless the latch was set on the previous cycle. The latch changes only after a qualified execute strobe. Flags reach the processor only while the device is selected, and the DMA strobe always follows a DMA-state timing strobe. Only the bench scenarios can show the rest. Those are whether a given device number sets or clears the latch, which strobe bit and which captured byte each code produces, and that the select code, code 0 and inputs sharing the select code number are handled correctly across back-to-back transfers.

// File: rtl/selio_pkg.sv
package selio_pkg;

  localparam int IO_CODE_W = 3;
  localparam int NUM_CODES = 1 << IO_CODE_W;

  typedef enum logic [1:0] {
    ST_FETCH = 2'b00,
    ST_EXEC  = 2'b01,
    ST_DMA   = 2'b10,
    ST_INTR  = 2'b11
  } cpuState_e;

  // Strobes from the control decode to the datapath.
  typedef struct packed {
    logic                 selWrite;
    logic                 outPulse;
    logic                 inPulse;
    logic                 dmaPulse;
    logic [IO_CODE_W-1:0] code;
  } ioCtl_t;

endpackage

// File: rtl/selio_ctrl.sv
module selio_ctrl
  import selio_pkg::*;
#(
  parameter logic [IO_CODE_W-1:0] SEL_CODE = 3'd1
) (
  input  logic [IO_CODE_W-1:0] ioCode,
  input  logic                 memRead,
  input  logic [1:0]           stateCode,
  input  logic                 tpb,
  output ioCtl_t               ctl
);

  logic execStrobe;
  logic transfer;
  logic isSelect;

  always_comb begin
    execStrobe = tpb && (stateCode == ST_EXEC);
    transfer   = execStrobe && (ioCode != '0);
    isSelect   = transfer && memRead && (ioCode == SEL_CODE);

    ctl.selWrite = isSelect;
    ctl.outPulse = transfer && memRead && !isSelect;
    ctl.inPulse  = transfer && !memRead;
    ctl.dmaPulse = tpb && (stateCode == ST_DMA);
    ctl.code     = ioCode;
  end

endmodule

// File: rtl/selio_dpath.sv
module selio_dpath
  import selio_pkg::*;
#(
  parameter int                DATA_W = 8,
  parameter int                FLAG_W = 4,
  parameter logic [DATA_W-1:0] DEV_ID = 8'h3C
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  ioCtl_t               ctl,
  input  logic [DATA_W-1:0]    dataBus,
  input  logic [FLAG_W-1:0]    devFlags,
  output logic                 selected,
  output logic [NUM_CODES-1:0] outStrobe,
  output logic [NUM_CODES-1:0] inStrobe,
  output logic [DATA_W-1:0]    outData,
  output logic [FLAG_W-1:0]    flagOut,
  output logic                 dmaStrobe
);

  logic [NUM_CODES-1:0] codeOneHot;
  logic                 idMatch;
  logic                 outAccept;
  logic                 inAccept;

  for (genvar i = 0; i < NUM_CODES; i++) begin : g_dec
    assign codeOneHot[i] = (ctl.code == IO_CODE_W'(i));
  end

  for (genvar f = 0; f < FLAG_W; f++) begin : g_flag
    assign flagOut[f] = selected & devFlags[f];
  end

  assign idMatch   = (dataBus == DEV_ID);
  assign outAccept = ctl.outPulse && selected;
  assign inAccept  = ctl.inPulse && selected;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      selected  <= 1'b0;
      outStrobe <= '0;
      inStrobe  <= '0;
      outData   <= '0;
      dmaStrobe <= 1'b0;
    end else begin
      if (ctl.selWrite) selected <= idMatch;
      outStrobe <= outAccept ? codeOneHot : '0;
      inStrobe  <= inAccept ? codeOneHot : '0;
      if (outAccept) outData <= dataBus;
      dmaStrobe <= ctl.dmaPulse;
    end
  end

endmodule

// File: rtl/selio_dev_select.sv
module selio_dev_select
  import selio_pkg::*;
#(
  parameter int                   DATA_W   = 8,
  parameter int                   FLAG_W   = 4,
  parameter logic [DATA_W-1:0]    DEV_ID   = 8'h3C,
  parameter logic [IO_CODE_W-1:0] SEL_CODE = 3'd1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IO_CODE_W-1:0] ioCode,
  input  logic                 memRead,
  input  logic [1:0]           stateCode,
  input  logic                 tpb,
  input  logic [DATA_W-1:0]    dataBus,
  input  logic [FLAG_W-1:0]    devFlags,
  output logic                 selected,
  output logic [NUM_CODES-1:0] outStrobe,
  output logic [NUM_CODES-1:0] inStrobe,
  output logic [DATA_W-1:0]    outData,
  output logic [FLAG_W-1:0]    flagOut,
  output logic                 dmaStrobe
);

  ioCtl_t ctl;

  selio_ctrl #(.SEL_CODE(SEL_CODE)) ctrl_i (
    .ioCode    (ioCode),
    .memRead   (memRead),
    .stateCode (stateCode),
    .tpb       (tpb),
    .ctl       (ctl)
  );

  selio_dpath #(.DATA_W(DATA_W), .FLAG_W(FLAG_W), .DEV_ID(DEV_ID)) dpath_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .dataBus   (dataBus),
    .devFlags  (devFlags),
    .selected  (selected),
    .outStrobe (outStrobe),
    .inStrobe  (inStrobe),
    .outData   (outData),
    .flagOut   (flagOut),
    .dmaStrobe (dmaStrobe)
  );

endmodule

// File: rtl/selio_dev_select_chk.sv
module selio_dev_select_chk
  import selio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FLAG_W = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [IO_CODE_W-1:0] ioCode,
  input logic                 memRead,
  input logic [1:0]           stateCode,
  input logic                 tpb,
  input logic [DATA_W-1:0]    dataBus,
  input logic [FLAG_W-1:0]    devFlags,
  input logic                 selected,
  input logic [NUM_CODES-1:0] outStrobe,
  input logic [NUM_CODES-1:0] inStrobe,
  input logic [DATA_W-1:0]    outData,
  input logic [FLAG_W-1:0]    flagOut,
  input logic                 dmaStrobe
);

  // R4 R5: one strobe at most, never both directions together
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({outStrobe, inStrobe}));

  // R6: any I/O strobe requires the latch set on the edge that made it
  a_r6_gated: assert property (@(posedge clk) disable iff (!rst_n)
    ((|outStrobe) || (|inStrobe)) |-> $past(selected));

  // R8: the latch moves only after a qualified execute strobe
  a_r8_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tpb && (stateCode == ST_EXEC)) |-> $stable(selected));

  // R7: flags reach the processor only when selected
  a_r7_flags_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (flagOut != '0) |-> selected);

  // R10: the DMA strobe follows a DMA-state timing strobe
  a_r10_dma: assert property (@(posedge clk) disable iff (!rst_n)
    dmaStrobe |-> $past(tpb && (stateCode == ST_DMA)));

endmodule

bind selio_dev_select selio_dev_select_chk #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) chk_i (.*);

// File: tb/selio_dev_select_tb_top.sv
module selio_dev_select_tb_top;

  localparam logic [7:0] DEV = 8'h3C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] ioCode = '0;
  logic       memRead = 1'b0;
  logic [1:0] stateCode = 2'b00;
  logic       tpb = 1'b0;
  logic [7:0] dataBus = '0;
  logic [3:0] devFlags = '0;
  logic       selected;
  logic [7:0] outStrobe;
  logic [7:0] inStrobe;
  logic [7:0] outData;
  logic [3:0] flagOut;
  logic       dmaStrobe;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  selio_dev_select dut_i (
    .clk(clk), .rst_n(rst_n), .ioCode(ioCode), .memRead(memRead),
    .stateCode(stateCode), .tpb(tpb), .dataBus(dataBus), .devFlags(devFlags),
    .selected(selected), .outStrobe(outStrobe), .inStrobe(inStrobe),
    .outData(outData), .flagOut(flagOut), .dmaStrobe(dmaStrobe)
  );

  typedef struct {
    string      tag;
    logic       sel;
    logic [7:0] outS;
    logic [7:0] inS;
    logic [7:0] data;
    logic       dma;
  } expItem_t;

  expItem_t   expQ[$];
  logic       mSel  = 1'b0;
  logic [7:0] mData = '0;

  task automatic checkVal(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Driver: one cycle of bus activity, expected outcome pushed to the scoreboard.
  task automatic op(string tag, bit t, logic [1:0] st, bit mr, logic [2:0] c, logic [7:0] d);
    expItem_t e;
    bit exec;
    @(negedge clk);
    tpb = t; stateCode = st; memRead = mr; ioCode = c; dataBus = d;
    e.tag = tag; e.outS = '0; e.inS = '0;
    e.dma = t && (st == 2'b10);
    exec = t && (st == 2'b01) && (c != 3'd0);
    if (exec) begin
      if (mr && c == 3'd1) mSel = (d == DEV);
      else if (mSel) begin
        if (mr) begin e.outS[c] = 1'b1; mData = d; end
        else e.inS[c] = 1'b1;
      end
    end
    e.sel = mSel; e.data = mData;
    expQ.push_back(e);
  endtask

  task automatic idle(string tag);
    op(tag, 1'b0, 2'b00, 1'b0, 3'd0, 8'h00);
  endtask

  // Monitor: pops the item of this edge and compares after it settles.
  initial begin
    expItem_t e;
    forever begin
      @(posedge clk);
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        @(negedge clk); #1;
        checkVal(e.tag, "selected",  32'(selected),  32'(e.sel));
        checkVal(e.tag, "outStrobe", 32'(outStrobe), 32'(e.outS));
        checkVal(e.tag, "inStrobe",  32'(inStrobe),  32'(e.inS));
        checkVal(e.tag, "outData",   32'(outData),   32'(e.data));
        checkVal(e.tag, "dmaStrobe", 32'(dmaStrobe), 32'(e.dma));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    checkVal("R1", "selected",  32'(selected),  0);
    checkVal("R1", "outStrobe", 32'(outStrobe), 0);
    checkVal("R1", "inStrobe",  32'(inStrobe),  0);
    checkVal("R1", "outData",   32'(outData),   0);
    checkVal("R1", "dmaStrobe", 32'(dmaStrobe), 0);
    devFlags = 4'b1011;
    #1 checkVal("R7", "flagOut deselected", 32'(flagOut), 0);

    op("R6", 1, 2'b01, 1, 3'd3, 8'h11);
    op("R6", 1, 2'b01, 0, 3'd5, 8'h22);
    op("R10", 1, 2'b10, 0, 3'd0, 8'h00);
    op("R2", 1, 2'b01, 1, 3'd1, DEV);
    idle("R2");
    op("R4", 1, 2'b01, 1, 3'd3, 8'hA5);
    op("R4", 1, 2'b01, 1, 3'd7, 8'h5E);
    idle("R4");
    op("R11", 1, 2'b01, 0, 3'd1, 8'h77);
    op("R5", 1, 2'b01, 0, 3'd7, 8'h00);
    op("R5", 1, 2'b01, 0, 3'd2, 8'h00);
    op("R9", 1, 2'b01, 1, 3'd0, 8'h00);
    op("R9", 1, 2'b01, 0, 3'd0, 8'h99);
    op("R8", 1, 2'b00, 1, 3'd1, 8'h00);
    op("R8", 0, 2'b01, 1, 3'd1, 8'h00);
    op("R8", 1, 2'b11, 1, 3'd4, 8'hEE);
    op("R8", 0, 2'b01, 1, 3'd4, 8'hEE);
    op("R10", 1, 2'b10, 1, 3'd4, 8'h00);
    op("R11", 1, 2'b01, 1, 3'd1, DEV);
    idle("R7");
    #1 checkVal("R7", "flagOut selected", 32'(flagOut), 32'(4'b1011));
    devFlags = 4'b0110;
    #1 checkVal("R7", "flagOut follows", 32'(flagOut), 32'(4'b0110));

    op("R3", 1, 2'b01, 1, 3'd1, 8'h3D);
    op("R6", 1, 2'b01, 1, 3'd2, 8'hC3);
    op("R6", 1, 2'b01, 0, 3'd6, 8'h00);
    op("R10", 1, 2'b10, 0, 3'd0, 8'h00);
    idle("R3");
    #1 checkVal("R7", "flagOut after deselect", 32'(flagOut), 0);

    op("R9", 1, 2'b01, 1, 3'd0, DEV);
    op("R2", 1, 2'b01, 1, 3'd1, DEV);
    op("R4", 1, 2'b01, 1, 3'd6, 8'h42);
    op("R3", 1, 2'b01, 1, 3'd1, 8'h00);
    op("R6", 1, 2'b01, 1, 3'd6, 8'h81);
    idle("R6");
    idle("R6");
    repeat (3) @(negedge clk);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule